// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative translation buffer that turns a 64-bit virtual address into a 32-bit physical page address. Each lookup also carries the current context number, a privilege flag and a read/write flag. Every valid slot is compared against the request in the same cycle. Each slot has its own page size: 8 KiB, 64 KiB, 512 KiB or 4 MiB. The comparison therefore ignores a different number of low address bits for each slot.

The response comes one cycle after the request. It holds the physical page address, the read and write grants, and a fault flag with a cause code and a trap identifier. A load port writes one slot per cycle by index, as a 64-bit tag and a 64-bit translation word. An enable input switches the unit into pass-through mode.

One parameter builds the block for data accesses, which check write permission. The same parameter can instead build it for instruction fetches, which grant read only. A second parameter sets the trap identifier, so the two builds report distinct fault codes.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is held (synchronous, active low), `rsp_valid` is 0. After reset, every slot is invalid, so an enabled lookup misses.
- R2: `rsp_valid` equals the value of `req_valid` one clock earlier. The other response fields belong to the request sampled at that edge.
- R3: A slot takes part only when translation-word bit 63 is 1 and tag bits 12:0 equal `cur_ctx`.
- R4: Translation-word bits 62:61 give the page size: 0, 1, 2 or 3. A slot of size s matches when virtual address bits 63:(13+3s) equal tag bits 63:(13+3s). Address bits below 13+3s do not affect the match.
- R5: On a granted hit, `rsp_pa` = {translation bits 31:13, 13 zero bits} and `rsp_rd` = 1. `rsp_wr` equals translation bit 1 in the data build and is 0 in the instruction build.
- R6: If the selected slot has translation bit 2 set and `req_priv` is 0, the lookup faults with cause 2.
- R7: In the data build, a write (`req_write` = 1) to a selected slot whose translation bit 1 is 0 faults with cause 3, provided R6 does not apply. The instruction build ignores `req_write`.
- R8: When no slot matches while enabled, the lookup faults with cause 1.
- R9: On a fault, `rsp_fault` = 1, `rsp_trap` = FAULT_ID, and `rsp_pa`, `rsp_rd` and `rsp_wr` are 0. Without a fault, `rsp_cause` and `rsp_trap` are 0.
- R10: With `mmu_en` = 0, nothing faults and `rsp_pa` = `req_va[31:0]` with `rsp_rd` = 1. `rsp_wr` is 1 in the data build and 0 in the instruction build.
- R11: When several slots match, the one with the lowest index supplies the result.
- R12: A slot write given without `req_valid` is seen by lookups from the next cycle on. A slot write given in the same cycle as `req_valid` is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | IDX_W | Index of the slot to write |
| cfg_tag | input | 64 | Tag: virtual page above bit 12, context in bits 12:0 |
| cfg_tte | input | 64 | Translation word: valid, size, physical page, privileged, writable |
| mmu_en | input | 1 | 1 = translate, 0 = pass through |
| cur_ctx | input | 13 | Current context number |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address |
| req_priv | input | 1 | Request is privileged |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 privilege, 3 write protect |
| rsp_trap | output | 8 | FAULT_ID on a fault, else 0 |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |

## Verification
Each lookup result is due exactly one rising edge after the edge that samples the request. A slot write is visible to a request sampled one edge after the write edge. The bench drives inputs on the falling edge and holds them for one full period. It reads every response at the next falling edge, half a period after the register loads. One idle falling edge later it confirms that `rsp_valid` has dropped. For each lookup the expected result comes from an independent reference model of the slot table, which the bench updates only for writes it knows the block accepts.

// File: rtl/tlb_pkg.sv
// Shared constants, field positions and types for the translation buffer.
// Assumes 64-bit virtual addresses, 13-bit contexts and a 32-bit physical space.
package tlb_pkg;
    localparam int VA_W      = 64;
    localparam int WORD_W    = 64;
    localparam int CTX_W     = 13;
    localparam int PA_W      = 32;
    localparam int PG_SHIFT  = 13;
    localparam int SZ_STEP   = 3;
    localparam int TRAP_W    = 8;
    localparam int VPN_W     = VA_W - PG_SHIFT;
    localparam int PPN_W     = PA_W - PG_SHIFT;

    localparam int W_VALID   = 63;
    localparam int W_SZ_HI   = 62;
    localparam int W_SZ_LO   = 61;
    localparam int W_PRIV    = 2;
    localparam int W_WRITE   = 1;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_MISS  = 2'd1,
        CAUSE_PRIV  = 2'd2,
        CAUSE_WPROT = 2'd3
    } cause_e;

    // Fields of one slot kept after decoding the written tag and word.
    typedef struct packed {
        logic             valid;
        logic [1:0]       size;
        logic             priv;
        logic             wr;
        logic [PPN_W-1:0] ppn;
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
    } slot_t;

    // Virtual-page compare mask: clears the 3*size lowest page-number bits.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] size);
        int unsigned drop;
        drop = SZ_STEP * int'(size);
        return {VPN_W{1'b1}} << drop;
    endfunction
endpackage

// File: rtl/tlb_slot_store.sv
// Slot storage: decodes each written tag/word pair into the fields the lookup
// needs and holds them per slot. Assumes at most one write per cycle; an index
// beyond ENTRIES-1 writes nothing. Reset clears every slot to invalid.
module tlb_slot_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WORD_W-1:0]     wr_tag,
    input  logic [WORD_W-1:0]     wr_tte,
    output slot_t [ENTRIES-1:0]   slots
);
    slot_t new_slot;
    logic  unused_word_bits;

    // Decode the incoming pair into slot fields.
    always_comb begin
        new_slot.valid = wr_tte[W_VALID];
        new_slot.size  = wr_tte[W_SZ_HI:W_SZ_LO];
        new_slot.priv  = wr_tte[W_PRIV];
        new_slot.wr    = wr_tte[W_WRITE];
        new_slot.ppn   = wr_tte[PA_W-1:PG_SHIFT];
        new_slot.vpn   = wr_tag[VA_W-1:PG_SHIFT];
        new_slot.ctx   = wr_tag[CTX_W-1:0];
    end

    assign unused_word_bits = ^{wr_tte[W_SZ_LO-1:PA_W], wr_tte[PG_SHIFT-1:W_PRIV+1], wr_tte[0]};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t q;

        // Hold slot g, loading it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= new_slot;
        end

        assign slots[g] = q;
    end
endmodule

// File: rtl/tlb_match_array.sv
// Parallel comparator: one match line per slot. A slot matches when it is valid,
// its context equals the current one, and the virtual page agrees above the
// slot's own page-size boundary. Purely combinational.
module tlb_match_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  slot_t [ENTRIES-1:0] slots,
    input  logic [VPN_W-1:0]    va_vpn,
    input  logic [CTX_W-1:0]    ctx,
    output logic [ENTRIES-1:0]  hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] msk;
        logic             ctx_ok;
        logic             page_ok;

        assign msk     = vpn_mask(slots[g].size);
        assign ctx_ok  = slots[g].ctx == ctx;
        assign page_ok = ((va_vpn ^ slots[g].vpn) & msk) == '0;
        assign hit[g]  = slots[g].valid && ctx_ok && page_ok;
    end
endmodule

// File: rtl/tlb_prio_enc.sv
// Priority encoder: returns the lowest set index of the request vector and
// whether any bit is set. Index is zero when nothing is set.
module tlb_prio_enc #(
    parameter int N       = 64,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
// Translation buffer top. It compares every slot against the request and picks
// the lowest matching index. It applies the privilege check and, in the data
// build, the write check, and registers the result so it appears one cycle after
// the request. With mmu_en low it passes the address through. A slot write given
// in the same cycle as a request is dropped. Assumes the caller keeps at most
// one request per cycle.
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int              ENTRIES     = 64,
    parameter bit              CHECK_WRITE = 1'b1,
    parameter logic [TRAP_W-1:0] FAULT_ID  = 8'h68,
    localparam int             IDX_W       = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_tag,
    input  logic [WORD_W-1:0] cfg_tte,
    input  logic              mmu_en,
    input  logic [CTX_W-1:0]  cur_ctx,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_priv,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [TRAP_W-1:0] rsp_trap,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_rd,
    output logic              rsp_wr
);
    slot_t [ENTRIES-1:0] slots;
    logic [ENTRIES-1:0]  hit_vec;
    logic                hit_any;
    logic [IDX_W-1:0]    hit_idx;
    slot_t               sel;
    logic                store_we;

    cause_e              nxt_cause;
    logic [PA_W-1:0]     nxt_pa;
    logic                nxt_rd;
    logic                nxt_wr;
    logic                unused_va_bits;

    assign store_we       = cfg_we && !req_valid;
    assign unused_va_bits = ^req_va[PG_SHIFT-1:0];

    tlb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_we),
        .wr_idx (cfg_idx),
        .wr_tag (cfg_tag),
        .wr_tte (cfg_tte),
        .slots  (slots)
    );

    tlb_match_array #(.ENTRIES(ENTRIES)) u_match (
        .slots  (slots),
        .va_vpn (req_va[VA_W-1:PG_SHIFT]),
        .ctx    (cur_ctx),
        .hit    (hit_vec)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_prio (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign sel = slots[hit_idx];

    // Decide the response for the current request: bypass, fault or grant.
    always_comb begin
        nxt_cause = CAUSE_NONE;
        nxt_pa    = '0;
        nxt_rd    = 1'b0;
        nxt_wr    = 1'b0;
        if (!mmu_en) begin
            nxt_pa = req_va[PA_W-1:0];
            nxt_rd = 1'b1;
            nxt_wr = CHECK_WRITE;
        end else if (!hit_any) begin
            nxt_cause = CAUSE_MISS;
        end else if (sel.priv && !req_priv) begin
            nxt_cause = CAUSE_PRIV;
        end else if (CHECK_WRITE && req_write && !sel.wr) begin
            nxt_cause = CAUSE_WPROT;
        end else begin
            nxt_pa = {sel.ppn, {PG_SHIFT{1'b0}}};
            nxt_rd = 1'b1;
            nxt_wr = CHECK_WRITE && sel.wr;
        end
    end

    // Register the response one cycle after a sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= 2'd0;
            rsp_trap  <= '0;
            rsp_pa    <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= nxt_cause != CAUSE_NONE;
                rsp_cause <= nxt_cause;
                rsp_trap  <= (nxt_cause != CAUSE_NONE) ? FAULT_ID : '0;
                rsp_pa    <= nxt_pa;
                rsp_rd    <= nxt_rd;
                rsp_wr    <= nxt_wr;
            end
        end
    end
endmodule

// File: rtl/tlb_lookup_chk.sv
// Port-level property checker for tlb_lookup, attached by bind below.
// Assumes the response follows the request sampled one edge earlier.
module tlb_lookup_chk
    import tlb_pkg::*;
#(
    parameter bit                CHECK_WRITE = 1'b1,
    parameter logic [TRAP_W-1:0] FAULT_ID    = 8'h68
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mmu_en,
    input logic              req_valid,
    input logic [PA_W-1:0]   req_va_lo,
    input logic              req_priv,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic [TRAP_W-1:0] rsp_trap,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_rd,
    input logic              rsp_wr
);
    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R9
    fault_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_rd && !rsp_wr && rsp_pa == '0 && rsp_trap == FAULT_ID);

    // R9
    clean_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_cause == 2'd0 && rsp_trap == '0);

    // R5
    grant_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_rd);

    // R6
    priv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause == 2'd2 |-> !$past(req_priv));

    // R7
    wprot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause == 2'd3 |-> $past(req_write) && CHECK_WRITE);

    // R10
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(mmu_en) |-> !rsp_fault && rsp_pa == $past(req_va_lo)
                                         && rsp_wr == CHECK_WRITE);
endmodule

bind tlb_lookup tlb_lookup_chk #(
    .CHECK_WRITE (CHECK_WRITE),
    .FAULT_ID    (FAULT_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mmu_en    (mmu_en),
    .req_valid (req_valid),
    .req_va_lo (req_va[tlb_pkg::PA_W-1:0]),
    .req_priv  (req_priv),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_trap  (rsp_trap),
    .rsp_pa    (rsp_pa),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr)
);

// File: tb/tb_tlb_lookup.sv
`timescale 1ns/1ps
module tb_tlb_lookup;
    import tlb_pkg::*;

    localparam int N  = 8;
    localparam int IW = $clog2(N);
    localparam logic [7:0] D_ID = 8'h68;
    localparam logic [7:0] I_ID = 8'h64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cfg_we, mmu_en, req_valid, req_priv, req_write;
    logic [IW-1:0] cfg_idx;
    logic [63:0] cfg_tag, cfg_tte, req_va;
    logic [12:0] cur_ctx;

    logic d_valid, d_fault, d_rd, d_wr, i_valid, i_fault, i_rd, i_wr;
    logic [1:0] d_cause, i_cause;
    logic [7:0] d_trap, i_trap;
    logic [31:0] d_pa, i_pa;

    tlb_lookup #(.ENTRIES(N), .CHECK_WRITE(1'b1), .FAULT_ID(D_ID)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag),
        .cfg_tte(cfg_tte), .mmu_en(mmu_en), .cur_ctx(cur_ctx), .req_valid(req_valid),
        .req_va(req_va), .req_priv(req_priv), .req_write(req_write),
        .rsp_valid(d_valid), .rsp_fault(d_fault), .rsp_cause(d_cause), .rsp_trap(d_trap),
        .rsp_pa(d_pa), .rsp_rd(d_rd), .rsp_wr(d_wr));

    tlb_lookup #(.ENTRIES(N), .CHECK_WRITE(1'b0), .FAULT_ID(I_ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag),
        .cfg_tte(cfg_tte), .mmu_en(mmu_en), .cur_ctx(cur_ctx), .req_valid(req_valid),
        .req_va(req_va), .req_priv(req_priv), .req_write(req_write),
        .rsp_valid(i_valid), .rsp_fault(i_fault), .rsp_cause(i_cause), .rsp_trap(i_trap),
        .rsp_pa(i_pa), .rsp_rd(i_rd), .rsp_wr(i_wr));

    logic [63:0] m_tag [N];
    logic [63:0] m_tte [N];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tte(bit v, logic [1:0] sz, logic [18:0] ppn, bit p, bit w);
        return {v, sz, 29'b0, ppn, 10'b0, p, w, 1'b0};
    endfunction

    function automatic logic [63:0] mk_tag(logic [63:0] va, logic [12:0] ctx);
        return {va[63:13], ctx};
    endfunction

    // Reference: {valid, fault, cause, trap, rd, wr, pa} packed into 64 bits.
    function automatic logic [63:0] model(logic [63:0] va, logic [12:0] ctx, bit priv,
                                          bit wr, bit en, bit cw, logic [7:0] id);
        logic [1:0] c = 2'd0;
        logic [31:0] pa = '0;
        bit r = 0, w = 0;
        int h = -1;
        if (!en) begin
            pa = va[31:0]; r = 1; w = cw;
        end else begin
            for (int i = 0; i < N; i++) begin
                int nb = 13 + 3 * int'(m_tte[i][62:61]);
                if (h < 0 && m_tte[i][63] && m_tag[i][12:0] == ctx && (va >> nb) == (m_tag[i] >> nb))
                    h = i;
            end
            if (h < 0) c = 2'd1;
            else if (m_tte[h][2] && !priv) c = 2'd2;
            else if (cw && wr && !m_tte[h][1]) c = 2'd3;
            else begin
                pa = {m_tte[h][31:13], 13'b0}; r = 1; w = cw && m_tte[h][1];
            end
        end
        return {18'b0, 1'b1, c != 2'd0, c, (c != 2'd0) ? id : 8'h00, r, w, pa};
    endfunction

    task automatic wr_entry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_tag = tag; cfg_tte = tte;
        @(negedge clk);
        cfg_we = 0;
        m_tag[idx] = tag; m_tte[idx] = tte;
    endtask

    task automatic look(input string r, input logic [63:0] va, input logic [12:0] ctx,
                        input bit priv, input bit wr, input bit en);
        @(negedge clk);
        req_valid = 1; req_va = va; cur_ctx = ctx; req_priv = priv; req_write = wr; mmu_en = en;
        @(negedge clk);
        req_valid = 0;
        chk({r, " data"}, {18'b0, d_valid, d_fault, d_cause, d_trap, d_rd, d_wr, d_pa},
            model(va, ctx, priv, wr, en, 1, D_ID));
        chk({r, " instr"}, {18'b0, i_valid, i_fault, i_cause, i_trap, i_rd, i_wr, i_pa},
            model(va, ctx, priv, wr, en, 0, I_ID));
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [63:0] base;
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
        rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_tag = '0; cfg_tte = '0;
        mmu_en = 1; cur_ctx = '0; req_valid = 0; req_va = '0; req_priv = 0; req_write = 0;
        repeat (3) @(negedge clk);
        // R1: response idle while reset is held.
        chk("R1 valid in reset", {62'b0, d_valid, i_valid}, 64'd0);
        rst_n = 1;
        // R1 R8: empty table misses.
        look("R1 R8 empty miss", 64'h0000_1234_5678_0000, 13'd0, 1, 0, 1);
        look("R8 empty miss ctx", 64'hFFFF_0000_0000_2000, 13'd7, 0, 1, 1);
        // R2: no request, response drops one edge later.
        @(negedge clk);
        chk("R2 valid drops", {62'b0, d_valid, i_valid}, 64'd0);

        // R12: write in the same cycle as a lookup is dropped.
        base = 64'h0000_0042_0040_0000;
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3; cfg_tag = mk_tag(base, 13'd9);
        cfg_tte = mk_tte(1, 2'd0, 19'h12345, 0, 1);
        req_valid = 1; req_va = base; cur_ctx = 13'd9; req_priv = 0; req_write = 0; mmu_en = 1;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        chk("R12 concurrent lookup sees old", {62'b0, d_fault, d_cause == 2'd1}, 64'd3);
        look("R12 collided write dropped", base, 13'd9, 0, 0, 1);
        wr_entry(3, mk_tag(base, 13'd9), mk_tte(1, 2'd0, 19'h12345, 0, 1));
        look("R12 write seen next cycle", base, 13'd9, 0, 0, 1);
        chk("R12 R5 pa", {32'b0, d_pa}, {32'b0, 19'h12345, 13'b0});

        // R4: every size against address bits on both sides of each boundary.
        base = 64'h8A5C_3E00_0000_0000;
        for (int s = 0; s < 4; s++) begin
            wr_entry(0, mk_tag(base, 13'd5), mk_tte(1, 2'(s), 19'(20'h40 + s), 0, 1));
            look("R4 exact", base, 13'd5, 0, 0, 1);
            for (int b = 0; b < 64; b++)
                look($sformatf("R4 size %0d bit %0d", s, b), base ^ (64'd1 << b), 13'd5, 1, 1, 1);
        end

        // R3: context mismatch and cleared valid bit.
        for (int c = 0; c < 16; c++)
            look($sformatf("R3 ctx %0d", c), base, 13'(c), 1, 0, 1);
        wr_entry(0, mk_tag(base, 13'd5), mk_tte(0, 2'd0, 19'h7, 0, 1));
        look("R3 invalid slot", base, 13'd5, 1, 0, 1);

        // R5 R6 R7: permission bits against request flags.
        base = 64'h0000_0000_1357_E000;
        for (int k = 0; k < 16; k++) begin
            wr_entry(1, mk_tag(base, 13'h1ABC), mk_tte(1, 2'd1, 19'h5A5A5, k[0], k[1]));
            look($sformatf("R5 R6 R7 perm %0d", k), base, 13'h1ABC, k[2], k[3], 1);
        end

        // R11: two matching slots, lowest index wins.
        base = 64'h0000_7000_00C0_0000;
        wr_entry(5, mk_tag(base, 13'd2), mk_tte(1, 2'd3, 19'h00555, 0, 0));
        wr_entry(2, mk_tag(base, 13'd2), mk_tte(1, 2'd0, 19'h00AAA, 0, 1));
        look("R11 lowest index", base, 13'd2, 0, 0, 1);
        chk("R11 pa from slot 2", {32'b0, d_pa}, {32'b0, 19'h00AAA, 13'b0});
        look("R11 only larger page", base + 64'h2000, 13'd2, 0, 0, 1);
        chk("R11 pa from slot 5", {32'b0, d_pa}, {32'b0, 19'h00555, 13'b0});

        // R10: pass-through ignores table and permission bits.
        look("R10 bypass hit addr", base, 13'd2, 0, 1, 0);
        look("R10 bypass miss addr", 64'hDEAD_BEEF_CAFE_F00D, 13'd0, 0, 1, 0);
        chk("R10 pa low bits", {32'b0, d_pa}, 64'h0000_0000_CAFE_F00D);

        // R3 R4 R5 R6 R7 R8 R11: mixed sweep over a fully loaded table.
        for (int i = 0; i < N; i++)
            wr_entry(i, mk_tag({40'h0, 3'($urandom_range(0, 7)), 21'($urandom)}, 13'($urandom_range(0, 3))),
                     mk_tte(bit'($urandom_range(0, 7) != 0), 2'($urandom), 19'($urandom),
                            bit'($urandom), bit'($urandom)));
        for (int t = 0; t < 400; t++) begin
            int e = $urandom_range(0, N - 1);
            logic [63:0] va = m_tag[e] ^ (64'($urandom) & 64'h003F_FFFF);
            if (t % 5 == 0) va = va ^ 64'h0000_0100_0000_0000;
            look("R4 R6 R7 R8 R11 sweep", va, 13'($urandom_range(0, 3)),
                 bit'($urandom), bit'($urandom), 1);
        end

        finished = 1;
        summary();
    end
endmodule